// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the write-only control port of an audio playback datapath. A host drives three wires (an active-low chip select, a serial clock and a data line), and each transfer loads one 9-bit value into a small, sparse bank of control registers. The registers feed the converter, volume, tone, mono-mix and output-mixer settings of the datapath in parallel. Every register starts from a fixed default after reset.

All three serial wires are brought into the system clock domain through a synchronizer. Each wire then passes a run-length filter, so a pulse on the serial clock that is shorter than a few system clock periods never reaches the shift logic. A transfer counts only if exactly sixteen serial clock rising edges occur while chip select is low. The value is applied when chip select returns high, and not before. A write to a reserved command address returns the whole bank to its defaults.

Top module: `ctl_serial_regs`

## Requirements
- R1: After reset the register outputs hold these values: dac_ctl_o 0x008 (soft mute bit 3 set), vol_left_o and vol_right_o 0x0FF, bass_o and treble_o 0x00F (intensity bits 3:0 = 1111, bypass), mono_mix_o 0x000, and every 9-bit field of mixer_o 0x050 (bits 6:4 = 101).
- R2: A transfer is 16 bits sent MSB first, each bit sampled on a serial clock rising edge while cs_n is low. Bits 15:9 are the register address and bits 8:0 are the data. Address 5 loads dac_ctl_o, 10 loads vol_left_o, 11 loads vol_right_o, 12 loads bass_o, 13 loads treble_o and 23 loads mono_mix_o. Addresses 34 to 39 load mixer_o fields 0 to 5, and field k occupies bits 9k+8:9k.
- R3: A complete 16-bit word changes no output while cs_n stays low. The word takes effect only after cs_n rises.
- R4: A transfer with fewer or more than 16 serial clock rising edges is discarded, and every output keeps its value.
- R5: A 16-bit write to any address not listed in R2, other than 15, leaves every output unchanged.
- R6: A 16-bit write to address 15, whatever its data bits, returns every output to its R1 value.
- R7: A serial clock high pulse lasting fewer than GLITCH_HOLD system clock cycles is not counted as an edge. A pulse held high for at least GLITCH_HOLD cycles is counted.
- R8: Serial clock and data activity while cs_n is high writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low; rising edge commits |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data, MSB first |
| dac_ctl_o | output | 9 | Converter control register (address 5) |
| vol_left_o | output | 9 | Left digital volume register (address 10) |
| vol_right_o | output | 9 | Right digital volume register (address 11) |
| bass_o | output | 9 | Bass control register (address 12) |
| treble_o | output | 9 | Treble control register (address 13) |
| mono_mix_o | output | 9 | Digital mono-mix register (address 23) |
| mixer_o | output | 54 | Six output-mixer registers (addresses 34 to 39), 9 bits each |

## Verification
The hardest situations to reach from the ports are a serial clock glitch placed inside an otherwise valid transfer and a word whose length is one bit off. In both, the register outputs either change or stay put, and nothing else is visible. The stimulus therefore places a short high pulse of one or two system cycles ahead of a full 16-bit word, which must still commit. It also places a pulse long enough to count, which turns the transfer into 17 edges, and that transfer must be dropped. A sweep over all 128 addresses then shows that only the twelve mapped ones land and that every other address is ignored.

// File: rtl/ctl_serial_pkg.sv
`timescale 1ns/1ps
package ctl_serial_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 9;
    localparam int WORD_W    = ADDR_W + DATA_W;
    localparam int NUM_REGS  = 12;
    localparam int MIX_REGS  = 6;
    localparam int MIX_FIRST = NUM_REGS - MIX_REGS;
    localparam int CAP_CNT_W = $clog2(WORD_W + 2);

    localparam logic [ADDR_W-1:0] ADDR_RESET_ALL = 7'd15;
    localparam logic [ADDR_W-1:0] ADDR_MIX_BASE  = 7'd34;

    typedef logic [DATA_W-1:0]  creg_t;
    typedef creg_t [NUM_REGS-1:0] bank_t;

    // Address that loads each storage slot.
    function automatic logic [ADDR_W-1:0] slot_addr(input int s);
        case (s)
            0:       slot_addr = 7'd5;
            1:       slot_addr = 7'd10;
            2:       slot_addr = 7'd11;
            3:       slot_addr = 7'd12;
            4:       slot_addr = 7'd13;
            5:       slot_addr = 7'd23;
            default: slot_addr = ADDR_MIX_BASE + ADDR_W'(s - MIX_FIRST);
        endcase
    endfunction

    // Reset value of each slot.
    function automatic creg_t slot_default(input int s);
        case (s)
            0:       slot_default = 9'h008;
            1, 2:    slot_default = 9'h0FF;
            3, 4:    slot_default = 9'h00F;
            5:       slot_default = 9'h000;
            default: slot_default = 9'h050;
        endcase
    endfunction

    function automatic bank_t bank_defaults();
        bank_t b;
        for (int s = 0; s < NUM_REGS; s++) begin
            b[s] = slot_default(s);
        end
        return b;
    endfunction

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int s = 0; s < NUM_REGS; s++) begin
            if (a == slot_addr(s)) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/ctl_edge_filter.sv
`timescale 1ns/1ps
module ctl_edge_filter #(
    parameter int              WIDTH       = 3,
    parameter int              SYNC_STAGES = 2,
    parameter int              HOLD        = 3,
    parameter logic [WIDTH-1:0] RST_VAL    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sampled_o,
    output logic [WIDTH-1:0] clean_o
);

    localparam int CNT_W = $clog2(HOLD + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       run;
        logic                   level;
    } lane_t;

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        lane_t lane_d, lane_q;

        always_comb begin
            lane_d      = lane_q;
            lane_d.sync = (lane_q.sync << 1) | SYNC_STAGES'(raw_i[g]);
            if (lane_q.sync[SYNC_STAGES-1] == lane_q.level) begin
                lane_d.run = '0;
            end else if (lane_q.run == CNT_W'(HOLD - 1)) begin
                lane_d.level = lane_q.sync[SYNC_STAGES-1];
                lane_d.run   = '0;
            end else begin
                lane_d.run = lane_q.run + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '{sync: {SYNC_STAGES{RST_VAL[g]}}, run: '0, level: RST_VAL[g]};
            end else begin
                lane_q <= lane_d;
            end
        end

        assign sampled_o[g] = lane_q.sync[SYNC_STAGES-1];
        assign clean_o[g]   = lane_q.level;
    end

endmodule

// File: rtl/ctl_word_capture.sv
`timescale 1ns/1ps
module ctl_word_capture
    import ctl_serial_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n_i,
    input  logic                 sclk_i,
    input  logic                 sdin_i,
    output logic                 wr_o,
    output logic [ADDR_W-1:0]    wr_addr_o,
    output logic [DATA_W-1:0]    wr_data_o,
    output logic [CAP_CNT_W-1:0] bit_cnt_o
);

    typedef struct packed {
        logic                 sclk_prev;
        logic                 cs_prev;
        logic [WORD_W-1:0]    shift;
        logic [CAP_CNT_W-1:0] count;
        logic                 wr;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d           = cap_q;
        cap_d.wr        = 1'b0;
        cap_d.sclk_prev = sclk_i;
        cap_d.cs_prev   = cs_n_i;
        if (!cs_n_i) begin
            if (cap_q.cs_prev) begin
                cap_d.count = '0;
            end else if (sclk_i && !cap_q.sclk_prev) begin
                cap_d.shift = {cap_q.shift[WORD_W-2:0], sdin_i};
                if (cap_q.count <= CAP_CNT_W'(WORD_W)) begin
                    cap_d.count = cap_q.count + 1'b1;
                end
            end
        end else if (!cap_q.cs_prev && cap_q.count == CAP_CNT_W'(WORD_W)) begin
            cap_d.wr   = 1'b1;
            cap_d.addr = cap_q.shift[WORD_W-1:DATA_W];
            cap_d.data = cap_q.shift[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{sclk_prev: 1'b0, cs_prev: 1'b1, shift: '0, count: '0,
                       wr: 1'b0, addr: '0, data: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wr_o      = cap_q.wr;
    assign wr_addr_o = cap_q.addr;
    assign wr_data_o = cap_q.data;
    assign bit_cnt_o = cap_q.count;

endmodule

// File: rtl/ctl_reg_bank.sv
`timescale 1ns/1ps
module ctl_reg_bank
    import ctl_serial_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output bank_t             bank_o
);

    typedef struct packed {
        bank_t regs;
    } bank_st_t;

    bank_st_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_i) begin
            if (wr_addr_i == ADDR_RESET_ALL) begin
                bank_d.regs = bank_defaults();
            end else begin
                for (int s = 0; s < NUM_REGS; s++) begin
                    if (wr_addr_i == slot_addr(s)) begin
                        bank_d.regs[s] = wr_data_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.regs <= bank_defaults();
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank_o = bank_q.regs;

endmodule

// File: rtl/ctl_serial_regs.sv
`timescale 1ns/1ps
module ctl_serial_regs
    import ctl_serial_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_HOLD = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         sclk,
    input  logic                         sdin,
    output logic [DATA_W-1:0]            dac_ctl_o,
    output logic [DATA_W-1:0]            vol_left_o,
    output logic [DATA_W-1:0]            vol_right_o,
    output logic [DATA_W-1:0]            bass_o,
    output logic [DATA_W-1:0]            treble_o,
    output logic [DATA_W-1:0]            mono_mix_o,
    output logic [MIX_REGS*DATA_W-1:0]   mixer_o
);

    localparam int LANES = 3;
    localparam logic [LANES-1:0] LANE_RST = 3'b100;

    logic [LANES-1:0]     lane_raw;
    logic [LANES-1:0]     lane_samp;
    logic [LANES-1:0]     lane_clean;
    logic                 wr_en;
    logic [ADDR_W-1:0]    wr_addr;
    logic [DATA_W-1:0]    wr_data;
    logic [CAP_CNT_W-1:0] bit_cnt;
    bank_t                bank;

    assign lane_raw = {cs_n, sclk, sdin};

    ctl_edge_filter #(
        .WIDTH      (LANES),
        .SYNC_STAGES(SYNC_STAGES),
        .HOLD       (GLITCH_HOLD),
        .RST_VAL    (LANE_RST)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (lane_raw),
        .sampled_o(lane_samp),
        .clean_o  (lane_clean)
    );

    ctl_word_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (lane_clean[2]),
        .sclk_i   (lane_clean[1]),
        .sdin_i   (lane_clean[0]),
        .wr_o     (wr_en),
        .wr_addr_o(wr_addr),
        .wr_data_o(wr_data),
        .bit_cnt_o(bit_cnt)
    );

    ctl_reg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .bank_o   (bank)
    );

    assign dac_ctl_o   = bank[0];
    assign vol_left_o  = bank[1];
    assign vol_right_o = bank[2];
    assign bass_o      = bank[3];
    assign treble_o    = bank[4];
    assign mono_mix_o  = bank[5];

    for (genvar k = 0; k < MIX_REGS; k++) begin : g_mix
        assign mixer_o[k*DATA_W +: DATA_W] = bank[MIX_FIRST + k];
    end

endmodule

// File: rtl/ctl_serial_regs_chk.sv
`timescale 1ns/1ps
module ctl_serial_regs_chk
    import ctl_serial_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           samp,
    input logic [2:0]           clean,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [DATA_W-1:0]    wr_data,
    input logic [CAP_CNT_W-1:0] bit_cnt,
    input bank_t                bank
);

    // R1: one cycle into reset the bank holds its defaults
    assert_reset_defaults_R1: assert property (@(posedge clk)
        !rst_n |=> bank == bank_defaults());

    // R2: a mapped write lands in its own slot on the next cycle
    for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == slot_addr(s)) |=> bank[s] == $past(wr_data));
    end

    // R3: without a write pulse the bank does not move
    assert_no_write_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank));

    // R3: a write is issued only while chip select is deasserted
    assert_commit_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> clean[2]);

    // R4: a write follows exactly a full-length word
    assert_word_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(bit_cnt) == CAP_CNT_W'(WORD_W));

    // R5: unmapped addresses leave the bank alone
    assert_unmapped_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_RESET_ALL && !addr_mapped(wr_addr)) |=> $stable(bank));

    // R6: the reset command restores every default
    assert_reset_command_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RESET_ALL) |=> bank == bank_defaults());

    // R7: a filtered level only moves to a value already seen by the synchronizer
    for (genvar g = 0; g < 3; g++) begin : g_lane
        assert_filter_settled_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(clean[g]) |-> $past(samp[g]) == clean[g]);
    end

    // R8: no bit counting while deselected
    assert_idle_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clean[2] |=> $stable(bit_cnt));

endmodule

bind ctl_serial_regs ctl_serial_regs_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .samp   (lane_samp),
    .clean  (lane_clean),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .bit_cnt(bit_cnt),
    .bank   (bank)
);

// File: tb/sim_ctl_serial_regs.sv
`timescale 1ns/1ps
module sim_ctl_serial_regs;

    localparam int HALF  = 6;
    localparam int NREG  = 12;
    localparam int SETTLE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdin = 1'b0;
    logic [8:0]  dac_ctl, vol_l, vol_r, bass, treble, mono;
    logic [53:0] mix;

    int errors = 0;
    int checks = 0;
    logic [8:0] model [NREG];

    always #4 clk = ~clk;

    ctl_serial_regs u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdin       (sdin),
        .dac_ctl_o  (dac_ctl),
        .vol_left_o (vol_l),
        .vol_right_o(vol_r),
        .bass_o     (bass),
        .treble_o   (treble),
        .mono_mix_o (mono),
        .mixer_o    (mix)
    );

    function automatic logic [8:0] dut_reg(int s);
        case (s)
            0:       return dac_ctl;
            1:       return vol_l;
            2:       return vol_r;
            3:       return bass;
            4:       return treble;
            5:       return mono;
            default: return mix[(s-6)*9 +: 9];
        endcase
    endfunction

    function automatic int bench_slot(int a);
        case (a)
            5:  return 0;
            10: return 1;
            11: return 2;
            12: return 3;
            13: return 4;
            23: return 5;
            default: return (a >= 34 && a <= 39) ? a - 28 : -1;
        endcase
    endfunction

    task automatic model_reset();
        model[0] = 9'h008;
        model[1] = 9'h0FF;
        model[2] = 9'h0FF;
        model[3] = 9'h00F;
        model[4] = 9'h00F;
        model[5] = 9'h000;
        for (int k = 6; k < NREG; k++) model[k] = 9'h050;
    endtask

    task automatic model_write(int a, logic [8:0] v);
        if (a == 15) model_reset();
        else if (bench_slot(a) >= 0) model[bench_slot(a)] = v;
    endtask

    task automatic check_all(string req);
        for (int s = 0; s < NREG; s++) begin
            checks++;
            if (dut_reg(s) !== model[s]) begin
                errors++;
                $display("FAIL %s slot %0d: actual %h expected %h", req, s, dut_reg(s), model[s]);
            end
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = v[i];
            ticks(HALF);
            sclk = 1'b1;
            ticks(HALF);
            sclk = 1'b0;
        end
    endtask

    // optional sclk pulse of glitch cycles ahead of the word (0 = none)
    task automatic xfer(logic [31:0] v, int n, int glitch);
        cs_n = 1'b0;
        ticks(HALF);
        if (glitch > 0) begin
            sclk = 1'b1;
            ticks(glitch);
            sclk = 1'b0;
            ticks(HALF);
        end
        shift_bits(v, n);
        ticks(HALF);
        cs_n = 1'b1;
        ticks(SETTLE);
    endtask

    task automatic write_reg(int a, logic [8:0] v);
        xfer({16'b0, a[6:0], v}, 16, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [8:0] v;
        ticks(5);
        rst_n = 1'b1;
        ticks(5);
        model_reset();
        check_all("R1");

        // R2 / R5: sweep every address except the reset command
        for (int a = 0; a < 128; a++) begin
            if (a == 15) continue;
            v = 9'((a * 37 + 11) ^ (a << 4));
            write_reg(a, v);
            model_write(a, v);
            check_all(bench_slot(a) >= 0 ? "R2" : "R5");
        end
        // R2: complementary pattern on mapped addresses
        for (int a = 0; a < 128; a++) begin
            if (bench_slot(a) < 0) continue;
            v = ~9'((a * 37 + 11) ^ (a << 4));
            write_reg(a, v);
            model_write(a, v);
            check_all("R2");
        end

        // R3: full word with chip select held low does not commit
        cs_n = 1'b0;
        ticks(HALF);
        shift_bits({16'b0, 7'd12, 9'h133}, 16);
        ticks(SETTLE);
        check_all("R3");
        cs_n = 1'b1;
        ticks(SETTLE);
        model_write(12, 9'h133);
        check_all("R3");

        // R4: short and long words are discarded
        xfer({17'b0, 7'd11, 9'h155} >> 1, 15, 0);
        check_all("R4");
        xfer({16'b0, 7'd11, 9'h155}, 17, 0);
        check_all("R4");

        // R7: one- and two-cycle pulses are ignored, a full-width pulse counts
        xfer({16'b0, 7'd10, 9'h0A5}, 16, 1);
        model_write(10, 9'h0A5);
        check_all("R7");
        xfer({16'b0, 7'd36, 9'h1C3}, 16, 2);
        model_write(36, 9'h1C3);
        check_all("R7");
        xfer({16'b0, 7'd5, 9'h0E1}, 16, HALF);
        check_all("R7");

        // R8: activity with chip select high writes nothing
        for (int i = 0; i < 20; i++) begin
            sdin = i[0];
            ticks(HALF);
            sclk = ~sclk;
        end
        sclk = 1'b0;
        ticks(SETTLE);
        check_all("R8");

        // R6: reset command restores defaults
        write_reg(15, 9'h1FF);
        model_write(15, 9'h1FF);
        check_all("R6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule